// File: doc/BRIEF.md
# Oscillator Loss Supervisor with Self-Clock Fallback

This block watches an external clock-monitor failure indication and decides how the chip answers an oscillator loss. The answer depends on three enables. With monitoring off, a loss goes unnoticed. With monitoring on but the fallback off, the block asks for a clock-monitor reset on the next edge. With both on, the block moves the chip into a self-clock mode. In that mode the PLL clock drives the system and a sticky interrupt flag is raised.

While the chip sits in its low-power wait state, a loss in fallback mode keeps the chip waiting. The block turns the regulator and PLL back on. It then requalifies the oscillator: 4096 consecutive oscillator cycles must be counted with no failure present. If a failure returns during a check, the count starts again. The checks repeat without limit until one passes, and they keep running after the chip leaves wait.

A wakeup interrupt or an external reset ends the wait state. If the oscillator has been requalified, the system runs on the oscillator clock. Otherwise it runs on the PLL clock in self-clock mode. An external reset also produces a one-cycle reset-sequence start pulse. Every control output comes from a flop.

Top module: `clkloss_supervisor`

## Requirements
- R1: While rst_n is low, and after it is released, the outputs stay at cm_rst_req=0, scm_active=0, scm_flag=0, scm_irq=0, pll_en=1, vreg_en=1, sysclk_sel=0 (0 = oscillator, 1 = PLL), in_wait=0 and rst_seq=0, until an input changes them.
- R2: When mon_en=0, mon_fail has no effect for any length of time. cm_rst_req stays 0, scm_active stays 0 and scm_flag stays 0.
- R3: When mon_en=1 and scm_en=0, cm_rst_req is 1 in the cycle after every cycle in which mon_fail is 1, whatever the value of scm_ie. It is 0 otherwise.
- R4: When mon_en=1 and scm_en=1, a cycle with mon_fail=1 while scm_active=0 sets scm_active=1, sysclk_sel=1 and scm_flag=1 on the next edge. If in_wait=1 it also sets pll_en=1 and vreg_en=1, and in_wait stays 1.
- R5: Self-clock mode ends only after 4096 consecutive edges that sample mon_fail=0. An edge that samples mon_fail=1 restarts the count from zero.
- R6: When the check passes, scm_active and sysclk_sel fall to 0 on that edge. Inside wait, pll_en becomes the inverse of pll_in_wait and vreg_en stays 1 until the wait state ends.
- R7: An edge that samples wait_req=1 while in_wait=0 sets in_wait=1. When scm_active=0, it also sets vreg_en=0 and makes pll_en the inverse of pll_in_wait.
- R8: While in_wait=1, a wake_irq=1 or ext_rst=1 clears in_wait and sets pll_en=1 and vreg_en=1. If the oscillator has already been requalified, sysclk_sel stays 0. rst_seq is 1 in the cycle after each cycle in which ext_rst is 1.
- R9: If the oscillator has not recovered, self-clock mode stays active through any length of wait. It also stays active (sysclk_sel=1) through a wait exit, and ends only when a later check passes.
- R10: scm_flag stays 1 until a cycle with flag_clr=1. If a set and a clear fall on the same edge, the set wins.
- R11: scm_irq is 1 exactly in the cycle after the flag's next value is 1 while scm_ie=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, used for counting |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_fail | input | 1 | Clock monitor reports oscillator failure |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| scm_ie | input | 1 | Self-clock interrupt enable |
| pll_in_wait | input | 1 | 1 = PLL off during wait |
| wait_req | input | 1 | Request to enter wait |
| wake_irq | input | 1 | Wakeup interrupt |
| ext_rst | input | 1 | External reset request |
| flag_clr | input | 1 | Software write-one-to-clear of the flag |
| cm_rst_req | output | 1 | Clock-monitor reset request |
| scm_active | output | 1 | Self-clock mode is active |
| scm_flag | output | 1 | Sticky self-clock interrupt flag |
| scm_irq | output | 1 | Self-clock interrupt request |
| pll_en | output | 1 | PLL enable |
| vreg_en | output | 1 | Regulator enable |
| sysclk_sel | output | 1 | System clock select, 0 oscillator, 1 PLL |
| in_wait | output | 1 | Chip is in wait |
| rst_seq | output | 1 | Reset sequence start pulse |

## Verification
The failure indication is driven under each enable combination. A monitor-off run separates "ignored" from "reset", and a reset-only run separates an immediate reset from a fallback. A failure that clears at once and then counts exactly 4095 and 4096 clean cycles pins down the qualification length. A failure that returns mid-count shows that the counter restarts. A failure that never clears, followed by a wake and by an external reset, tells the recovered exit (oscillator clock) apart from the unrecovered exit (PLL clock with checks still running). The PLL-in-wait setting is tried both ways to show where the PLL is dropped after the check passes.

// File: rtl/clkloss_pkg.sv
// Package: shared constants for the oscillator loss supervisor.
// Assumes one oscillator-cycle counter sized for the qualification window.
package clkloss_pkg;
    localparam int QUAL_CYCLES = 4096;
    localparam int CNT_W       = $clog2(QUAL_CYCLES) + 1;
    typedef logic [CNT_W-1:0] qcnt_t;
endpackage

// File: rtl/clkloss_qual_cnt.sv
// Module: oscillator quality counter.
// Counts consecutive oscillator cycles with no failure while a check runs,
// and pulses done on the cycle that completes the window.
// Assumes run is a registered level that drops the cycle after done.
module clkloss_qual_cnt #(
    parameter int QUAL_CYCLES = clkloss_pkg::QUAL_CYCLES,
    parameter int CNT_W       = clkloss_pkg::CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fail,
    output logic done
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(QUAL_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal count reached on a clean cycle.
    assign done = run && !fail && (cnt == TERM);

    // Advance on clean cycles, restart on failure or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || fail) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkloss_flag.sv
// Module: sticky self-clock flag and its interrupt request.
// Set wins over a same-cycle software clear; the request is gated by the enable.
module clkloss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    logic flag_nx;

    // Next flag value: set has priority over clear.
    assign flag_nx = set || (flag && !clr);

    // Register the flag and the gated request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            flag <= flag_nx;
            irq  <= flag_nx && ie;
        end
    end
endmodule

// File: rtl/clkloss_ctrl.sv
// Module: wait state and self-clock mode control.
// Holds the wait state, the self-clock state and the PLL, regulator and
// clock-select outputs, all as flops. Assumes qual_done only pulses while
// scm_active is 1.
module clkloss_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_fail,
    input  logic mon_en,
    input  logic scm_en,
    input  logic pll_in_wait,
    input  logic wait_req,
    input  logic wake_irq,
    input  logic ext_rst,
    input  logic qual_done,
    output logic scm_enter,
    output logic cm_rst_req,
    output logic scm_active,
    output logic pll_en,
    output logic vreg_en,
    output logic sysclk_sel,
    output logic in_wait,
    output logic rst_seq
);
    logic wake_evt;

    // Fallback entry and wait exit events.
    assign scm_enter = mon_en && scm_en && mon_fail && !scm_active;
    assign wake_evt  = in_wait && (wake_irq || ext_rst);

    // Reset request and reset-sequence pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_rst_req <= 1'b0;
            rst_seq    <= 1'b0;
        end else begin
            cm_rst_req <= mon_en && !scm_en && mon_fail;
            rst_seq    <= ext_rst;
        end
    end

    // Self-clock mode and clock select change on the same transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scm_active <= 1'b0;
            sysclk_sel <= 1'b0;
        end else if (scm_enter) begin
            scm_active <= 1'b1;
            sysclk_sel <= 1'b1;
        end else if (qual_done) begin
            scm_active <= 1'b0;
            sysclk_sel <= 1'b0;
        end
    end

    // Wait state entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_wait <= 1'b0;
        end else if (!in_wait && wait_req) begin
            in_wait <= 1'b1;
        end else if (wake_evt) begin
            in_wait <= 1'b0;
        end
    end

    // PLL and regulator enables across run, wait and fallback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en  <= 1'b1;
            vreg_en <= 1'b1;
        end else if (wake_evt) begin
            pll_en  <= 1'b1;
            vreg_en <= 1'b1;
        end else if (in_wait) begin
            if (scm_enter) begin
                pll_en  <= 1'b1;
                vreg_en <= 1'b1;
            end else if (qual_done) begin
                pll_en  <= !pll_in_wait;
            end
        end else if (wait_req) begin
            pll_en  <= !pll_in_wait || scm_active || scm_enter;
            vreg_en <= scm_active || scm_enter;
        end else begin
            pll_en  <= 1'b1;
            vreg_en <= 1'b1;
        end
    end
endmodule

// File: rtl/clkloss_supervisor.sv
// Module: top of the oscillator loss supervisor.
// Connects the control state, the quality counter and the sticky flag.
// Assumes every input is synchronous to the oscillator clock.
module clkloss_supervisor #(
    parameter int QUAL_CYCLES = clkloss_pkg::QUAL_CYCLES,
    parameter int CNT_W       = $clog2(QUAL_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_fail,
    input  logic mon_en,
    input  logic scm_en,
    input  logic scm_ie,
    input  logic pll_in_wait,
    input  logic wait_req,
    input  logic wake_irq,
    input  logic ext_rst,
    input  logic flag_clr,
    output logic cm_rst_req,
    output logic scm_active,
    output logic scm_flag,
    output logic scm_irq,
    output logic pll_en,
    output logic vreg_en,
    output logic sysclk_sel,
    output logic in_wait,
    output logic rst_seq
);
    logic qual_done;
    logic scm_enter;

    clkloss_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .mon_fail(mon_fail), .mon_en(mon_en),
        .scm_en(scm_en), .pll_in_wait(pll_in_wait), .wait_req(wait_req),
        .wake_irq(wake_irq), .ext_rst(ext_rst), .qual_done(qual_done),
        .scm_enter(scm_enter), .cm_rst_req(cm_rst_req), .scm_active(scm_active),
        .pll_en(pll_en), .vreg_en(vreg_en), .sysclk_sel(sysclk_sel),
        .in_wait(in_wait), .rst_seq(rst_seq)
    );

    clkloss_qual_cnt #(.QUAL_CYCLES(QUAL_CYCLES), .CNT_W(CNT_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .run(scm_active), .fail(mon_fail),
        .done(qual_done)
    );

    clkloss_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(scm_enter), .clr(flag_clr),
        .ie(scm_ie), .flag(scm_flag), .irq(scm_irq)
    );
endmodule

// File: rtl/clkloss_checker.sv
// Module: property checker for the supervisor, bound to the top module.
module clkloss_checker (
    input logic clk,
    input logic rst_n,
    input logic mon_fail,
    input logic mon_en,
    input logic scm_en,
    input logic wake_irq,
    input logic ext_rst,
    input logic flag_clr,
    input logic cm_rst_req,
    input logic scm_active,
    input logic scm_flag,
    input logic pll_en,
    input logic vreg_en,
    input logic in_wait
);
    a_r3_cm_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !scm_en && mon_fail) |=> cm_rst_req);

    a_r2_monitor_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !scm_active) |=> !scm_active);

    a_r4_flag_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scm_active) |-> scm_flag);

    a_r4_power_in_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_active && in_wait) |-> (vreg_en && pll_en));

    a_r5_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_active && mon_fail) |=> scm_active);

    a_r6_vreg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && vreg_en && !wake_irq && !ext_rst) |=> vreg_en);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_flag && !flag_clr) |=> scm_flag);
endmodule

bind clkloss_supervisor clkloss_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mon_fail(mon_fail), .mon_en(mon_en),
    .scm_en(scm_en), .wake_irq(wake_irq), .ext_rst(ext_rst),
    .flag_clr(flag_clr), .cm_rst_req(cm_rst_req), .scm_active(scm_active),
    .scm_flag(scm_flag), .pll_en(pll_en), .vreg_en(vreg_en), .in_wait(in_wait)
);

// File: tb/sim_clkloss_supervisor.sv
module sim_clkloss_supervisor;
    logic clk = 1'b0;
    logic rst_n, mon_fail, mon_en, scm_en, scm_ie, pll_in_wait;
    logic wait_req, wake_irq, ext_rst, flag_clr;
    logic cm_rst_req, scm_active, scm_flag, scm_irq, pll_en, vreg_en;
    logic sysclk_sel, in_wait, rst_seq;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   ended  = 1'b0;

    always #5 clk = ~clk;

    clkloss_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .mon_fail(mon_fail), .mon_en(mon_en),
        .scm_en(scm_en), .scm_ie(scm_ie), .pll_in_wait(pll_in_wait),
        .wait_req(wait_req), .wake_irq(wake_irq), .ext_rst(ext_rst),
        .flag_clr(flag_clr), .cm_rst_req(cm_rst_req), .scm_active(scm_active),
        .scm_flag(scm_flag), .scm_irq(scm_irq), .pll_en(pll_en),
        .vreg_en(vreg_en), .sysclk_sel(sysclk_sel), .in_wait(in_wait),
        .rst_seq(rst_seq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Bring the block back to a clean run state.
    task automatic do_reset();
        rst_n = 1'b0; mon_fail = 1'b0; mon_en = 1'b0; scm_en = 1'b0;
        scm_ie = 1'b0; pll_in_wait = 1'b1; wait_req = 1'b0; wake_irq = 1'b0;
        ext_rst = 1'b0; flag_clr = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic enter_wait(input logic pw);
        pll_in_wait = pw; wait_req = 1'b1; tick(1); wait_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "cm_rst_req", cm_rst_req, 1'b0);
        chk("R1", "scm_active", scm_active, 1'b0);
        chk("R1", "scm_flag", scm_flag, 1'b0);
        chk("R1", "pll_en", pll_en, 1'b1);
        chk("R1", "vreg_en", vreg_en, 1'b1);
        chk("R1", "sysclk_sel", sysclk_sel, 1'b0);
        chk("R1", "in_wait", in_wait, 1'b0);
    endtask

    task automatic t_monitor_off();
        do_reset();
        enter_wait(1'b1);
        chk("R7", "in_wait", in_wait, 1'b1);
        chk("R7", "pll_en", pll_en, 1'b0);
        chk("R7", "vreg_en", vreg_en, 1'b0);
        mon_fail = 1'b1; scm_en = 1'b1; tick(20);
        chk("R2", "scm_active", scm_active, 1'b0);
        chk("R2", "cm_rst_req", cm_rst_req, 1'b0);
        chk("R2", "scm_flag", scm_flag, 1'b0);
        chk("R2", "vreg_en", vreg_en, 1'b0);
    endtask

    task automatic t_cm_reset();
        do_reset();
        mon_en = 1'b1; scm_ie = 1'b1;
        chk("R3", "cm_rst_req idle", cm_rst_req, 1'b0);
        mon_fail = 1'b1; tick(1);
        chk("R3", "cm_rst_req", cm_rst_req, 1'b1);
        chk("R3", "scm_active", scm_active, 1'b0);
        mon_fail = 1'b0; tick(1);
        chk("R3", "cm_rst_req drop", cm_rst_req, 1'b0);
    endtask

    // Recovered oscillator, exit by wakeup; PLL dropped after the check.
    task automatic t_recover_wake();
        do_reset();
        mon_en = 1'b1; scm_en = 1'b1;
        enter_wait(1'b1);
        mon_fail = 1'b1; tick(1);
        chk("R4", "scm_active", scm_active, 1'b1);
        chk("R4", "sysclk_sel", sysclk_sel, 1'b1);
        chk("R4", "scm_flag", scm_flag, 1'b1);
        chk("R4", "pll_en", pll_en, 1'b1);
        chk("R4", "vreg_en", vreg_en, 1'b1);
        chk("R4", "in_wait", in_wait, 1'b1);
        chk("R11", "scm_irq masked", scm_irq, 1'b0);
        mon_fail = 1'b0; tick(4095);
        chk("R5", "scm_active at 4095", scm_active, 1'b1);
        tick(1);
        chk("R5", "scm_active at 4096", scm_active, 1'b0);
        chk("R6", "sysclk_sel", sysclk_sel, 1'b0);
        chk("R6", "pll_en", pll_en, 1'b0);
        chk("R6", "vreg_en", vreg_en, 1'b1);
        tick(10);
        chk("R6", "vreg_en held", vreg_en, 1'b1);
        wake_irq = 1'b1; tick(1); wake_irq = 1'b0;
        chk("R8", "in_wait", in_wait, 1'b0);
        chk("R8", "sysclk_sel", sysclk_sel, 1'b0);
        chk("R8", "pll_en", pll_en, 1'b1);
        chk("R8", "rst_seq", rst_seq, 1'b0);
        chk("R10", "scm_flag sticky", scm_flag, 1'b1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk("R10", "scm_flag cleared", scm_flag, 1'b0);
    endtask

    // Failure returns mid-check; PLL kept in wait; exit by external reset.
    task automatic t_restart_reset();
        do_reset();
        mon_en = 1'b1; scm_en = 1'b1;
        enter_wait(1'b0);
        mon_fail = 1'b1; tick(1);
        mon_fail = 1'b0; tick(2000);
        mon_fail = 1'b1; tick(1);
        mon_fail = 1'b0; tick(4095);
        chk("R5", "restart scm_active at 4095", scm_active, 1'b1);
        tick(1);
        chk("R5", "restart scm_active at 4096", scm_active, 1'b0);
        chk("R6", "pll_en kept", pll_en, 1'b1);
        ext_rst = 1'b1; tick(1); ext_rst = 1'b0;
        chk("R8", "rst_seq", rst_seq, 1'b1);
        chk("R8", "in_wait", in_wait, 1'b0);
        chk("R8", "sysclk_sel", sysclk_sel, 1'b0);
        tick(1);
        chk("R8", "rst_seq pulse", rst_seq, 1'b0);
    endtask

    // Oscillator never recovers in wait; exit stays on PLL clock.
    task automatic t_no_recover();
        do_reset();
        mon_en = 1'b1; scm_en = 1'b1; scm_ie = 1'b1;
        enter_wait(1'b1);
        mon_fail = 1'b1; tick(1);
        chk("R11", "scm_irq", scm_irq, 1'b1);
        tick(10000);
        chk("R9", "scm_active in wait", scm_active, 1'b1);
        wake_irq = 1'b1; tick(1); wake_irq = 1'b0;
        chk("R9", "in_wait", in_wait, 1'b0);
        chk("R9", "sysclk_sel after exit", sysclk_sel, 1'b1);
        chk("R9", "scm_active after exit", scm_active, 1'b1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk("R10", "flag cleared", scm_flag, 1'b0);
        chk("R11", "irq cleared", scm_irq, 1'b0);
        mon_fail = 1'b0; tick(4095);
        chk("R9", "still fallback", sysclk_sel, 1'b1);
        tick(1);
        chk("R9", "sysclk_sel after pass", sysclk_sel, 1'b0);
        chk("R9", "scm_active after pass", scm_active, 1'b0);
    endtask

    // Set and clear on the same edge.
    task automatic t_set_wins();
        do_reset();
        mon_en = 1'b1; scm_en = 1'b1;
        mon_fail = 1'b1; flag_clr = 1'b1; tick(1);
        mon_fail = 1'b0; flag_clr = 1'b0;
        chk("R10", "set wins", scm_flag, 1'b1);
        chk("R4", "fallback outside wait", sysclk_sel, 1'b1);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_monitor_off();
        t_cm_reset();
        t_recover_wake();
        t_restart_reset();
        t_no_recover();
        t_set_wins();
        finish_run();
    end
endmodule